// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits at the entry of a graphics engine's command port. It takes 32-bit command words one at a time and groups them into packets. The top byte of the first word selects the packet kind and, through a length table that the block computes, how many parameter words follow. Drawing packets leave the block word by word, marked first and last, together with their table length. Rectangle copy and rectangle read packets are turned into single-cycle descriptors. Environment words update the low status bits and do not leave the block.

A rectangle write packet switches the block into payload mode. Each later word carries two 16-bit pixels. The block sends them out one per cycle as a pixel write stream, with X and Y addresses that wrap at 1024 and 512. When environment bit 6.0 is set, bit 15 of every pixel is forced to 1. Command parsing starts again only after all W×H pixels of the rectangle have been drained.

Top module: `gpu_packet_framer`

## Requirements
- R1: After reset `in_ready` is 1, `img_busy` is 0, `status` is 0 and no output valid is asserted.
- R2: A drawing packet is echoed word by word on `pkt_*` one cycle after each word is accepted. The first word has `pkt_first`=1 and the last word has `pkt_last`=1. `pkt_len` gives the table count of parameter words, for example 3 for opcode 0x20, 11 for 0x3C, 2 for 0x60 and 0 for 0x00 and 0x6C.
- R3: Polyline opcodes (0x48–0x4F and 0x58–0x5F) end on a word that equals 0x5000_5000 under the mask 0xF000_F000. For the single-colour kind (opcode bit 4 = 0) the check applies from word index 3 on. For the shaded kind (opcode bit 4 = 1) it applies only at even word indices from 4 on. A matching word anywhere else is ordinary data.
- R4: Opcodes 0x80–0x9F take three parameter words: source position, destination position and size. They produce one `copy_valid` pulse and no `pkt_valid`.
- R5: Opcodes 0xC0–0xDF (top three bits 110) take position and size words. They produce one `read_valid` pulse and no pixels, and `img_busy` stays 0.
- R6: A position word decodes as X = bits[9:0] and Y = bits[24:16]. A size word s decodes as W = ((s−1) & 0x3FF)+1 and H = (((s>>16)−1) & 0x1FF)+1, so a size of 0 means 1024×512.
- R7: Opcodes 0xA0–0xBF start a write. `img_busy` rises after the size word. Each payload word gives its bits[15:0] pixel first and its bits[31:16] pixel second. Pixels go left to right, then top to bottom. `img_busy` falls on the cycle the final pixel is output, and command parsing resumes with the next word.
- R8: Pixel X wraps from 1023 to 0 and pixel Y wraps from 511 to 0.
- R9: Every written pixel has bit 15 ORed with environment register 6 bit 0.
- R10: Opcodes 0xE0–0xE7 are single-word packets and are not echoed. `status[10:0]` takes bits[10:0] of the last 0xE1 word, and `status[12:11]` takes bits[1:0] of the last 0xE6 word. Other environment words leave `status` unchanged. `status` changes only when a word is accepted.
- R11: In payload mode the block accepts at most one word every two cycles and outputs one pixel per cycle. When the pixel count is odd, the upper half of the last word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| pkt_valid | output | 1 | Drawing packet word valid |
| pkt_data | output | 32 | Drawing packet word |
| pkt_first | output | 1 | Word is the packet opcode word |
| pkt_last | output | 1 | Word ends the packet |
| pkt_len | output | 4 | Table parameter count of the packet |
| copy_valid | output | 1 | Rectangle copy descriptor pulse |
| read_valid | output | 1 | Rectangle read descriptor pulse |
| rect_x | output | 10 | Source / read X |
| rect_y | output | 9 | Source / read Y |
| rect_w | output | 11 | Rectangle width 1..1024 |
| rect_h | output | 10 | Rectangle height 1..512 |
| copy_dst_x | output | 10 | Copy destination X |
| copy_dst_y | output | 9 | Copy destination Y |
| pix_valid | output | 1 | Pixel write valid |
| pix_x | output | 10 | Pixel X address |
| pix_y | output | 9 | Pixel Y address |
| pix_data | output | 16 | Pixel value with mask bit applied |
| status | output | 13 | Environment-derived status bits |
| img_busy | output | 1 | Write transfer in progress |

## Verification
Drawing packets of lengths 0, 2, 3 and 11 show whether the end of a packet follows the table rather than a fixed count. Polylines carry terminator-like words before their minimum length and at odd shaded positions, which separates the real terminator rule from a plain pattern match. A 3×2 write placed at the corner (1022, 511) exercises both address wraps and the low-half-first pixel order in one run. A 1×1 masked write followed by a command word shows that the unused upper half is dropped and that parsing resumes on the correct word. Size fields of 0 and 0x401 probe the minus-one/mask/plus-one decode at its extremes.

// File: rtl/gpu_packet_framer.sv
module gpu_packet_framer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        pkt_valid,
  output logic [31:0] pkt_data,
  output logic        pkt_first,
  output logic        pkt_last,
  output logic [3:0]  pkt_len,
  output logic        copy_valid,
  output logic        read_valid,
  output logic [9:0]  rect_x,
  output logic [8:0]  rect_y,
  output logic [10:0] rect_w,
  output logic [9:0]  rect_h,
  output logic [9:0]  copy_dst_x,
  output logic [8:0]  copy_dst_y,
  output logic        pix_valid,
  output logic [9:0]  pix_x,
  output logic [8:0]  pix_y,
  output logic [15:0] pix_data,
  output logic [12:0] status,
  output logic        img_busy
);

  typedef enum logic {S_CMD, S_PIX} state_t;

  function automatic logic [3:0] param_count(input logic [7:0] o);
    case (o) inside
      8'h02:           return 4'd2;
      [8'h20:8'h23]:   return 4'd3;
      [8'h24:8'h27]:   return 4'd6;
      [8'h28:8'h2B]:   return 4'd4;
      [8'h2C:8'h2F]:   return 4'd8;
      [8'h30:8'h33]:   return 4'd5;
      [8'h34:8'h37]:   return 4'd8;
      [8'h38:8'h3B]:   return 4'd7;
      [8'h3C:8'h3F]:   return 4'd11;
      [8'h40:8'h47]:   return 4'd2;
      [8'h48:8'h57]:   return 4'd3;
      [8'h58:8'h5F]:   return 4'd4;
      [8'h60:8'h63]:   return 4'd2;
      [8'h64:8'h67]:   return 4'd3;
      [8'h68:8'h6B]:   return 4'd1;
      [8'h70:8'h73]:   return 4'd1;
      [8'h74:8'h77]:   return 4'd2;
      [8'h78:8'h7B]:   return 4'd1;
      [8'h7C:8'h7F]:   return 4'd2;
      [8'h80:8'h9F]:   return 4'd3;
      [8'hA0:8'hDF]:   return 4'd2;
      default:         return 4'd0;
    endcase
  endfunction

  state_t      st;
  logic [7:0]  op;
  logic [3:0]  need, idx;
  logic        par;
  logic [9:0]  p1_x, p2_x;
  logic [8:0]  p1_y, p2_y;
  logic        half;
  logic [15:0] hold;
  logic [9:0]  x0, cx, col, wm1;
  logic [8:0]  cy, row, hm1;
  logic [10:0] env1;
  logic [1:0]  env6;

  wire        acc      = in_valid && in_ready;
  wire        first_w  = (idx == 4'd0);
  wire [7:0]  cur_op   = first_w ? in_data[31:24] : op;
  wire [3:0]  cur_need = first_w ? param_count(in_data[31:24]) : need;
  wire        is_poly  = (cur_op & 8'hE8) == 8'h48;
  wire        is_term  = (in_data & 32'hF000_F000) == 32'h5000_5000;
  wire        poly_end = is_term && (idx >= cur_need) && (!cur_op[4] || !par);
  wire        pkt_end  = is_poly ? poly_end : (idx == cur_need);
  wire        is_copy  = cur_op[7:5] == 3'b100;
  wire        is_write = cur_op[7:5] == 3'b101;
  wire        is_read  = cur_op[7:5] == 3'b110;
  wire        is_env   = cur_op[7:3] == 5'b11100;
  wire        generic  = !(is_copy || is_write || is_read || is_env);
  wire [9:0]  s_wm1    = in_data[9:0] - 10'd1;
  wire [8:0]  s_hm1    = in_data[24:16] - 9'd1;
  wire        pix_last = (col == wm1) && (row == hm1);

  assign in_ready = (st == S_CMD) || !half;
  assign status   = {env6, env1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; op <= '0; need <= '0; idx <= '0; par <= 1'b0;
      p1_x <= '0; p1_y <= '0; p2_x <= '0; p2_y <= '0;
      half <= 1'b0; hold <= '0;
      x0 <= '0; cx <= '0; cy <= '0; col <= '0; row <= '0; wm1 <= '0; hm1 <= '0;
      env1 <= '0; env6 <= '0;
      pkt_valid <= 1'b0; pkt_data <= '0; pkt_first <= 1'b0; pkt_last <= 1'b0; pkt_len <= '0;
      copy_valid <= 1'b0; read_valid <= 1'b0;
      rect_x <= '0; rect_y <= '0; rect_w <= '0; rect_h <= '0;
      copy_dst_x <= '0; copy_dst_y <= '0;
      pix_valid <= 1'b0; pix_x <= '0; pix_y <= '0; pix_data <= '0;
      img_busy <= 1'b0;
    end else begin
      pkt_valid  <= 1'b0;
      copy_valid <= 1'b0;
      read_valid <= 1'b0;
      pix_valid  <= 1'b0;
      if (st == S_CMD) begin
        if (acc) begin
          if (first_w) begin
            op   <= in_data[31:24];
            need <= cur_need;
          end
          if (idx == 4'd1) begin p1_x <= in_data[9:0]; p1_y <= in_data[24:16]; end
          if (idx == 4'd2) begin p2_x <= in_data[9:0]; p2_y <= in_data[24:16]; end
          if (generic) begin
            pkt_valid <= 1'b1;
            pkt_data  <= in_data;
            pkt_first <= first_w;
            pkt_last  <= pkt_end;
            pkt_len   <= cur_need;
          end
          if (pkt_end) begin
            idx <= '0;
            par <= 1'b0;
            if (is_env && cur_op[2:0] == 3'd1) env1 <= in_data[10:0];
            if (is_env && cur_op[2:0] == 3'd6) env6 <= in_data[1:0];
            if (is_copy || is_read) begin
              copy_valid <= is_copy;
              read_valid <= is_read;
              rect_x <= p1_x;
              rect_y <= p1_y;
              rect_w <= {1'b0, s_wm1} + 11'd1;
              rect_h <= {1'b0, s_hm1} + 10'd1;
            end
            if (is_copy) begin
              copy_dst_x <= p2_x;
              copy_dst_y <= p2_y;
            end
            if (is_write) begin
              st <= S_PIX; img_busy <= 1'b1; half <= 1'b0;
              x0 <= p1_x; cx <= p1_x; cy <= p1_y;
              col <= '0; row <= '0; wm1 <= s_wm1; hm1 <= s_hm1;
            end
          end else begin
            if (idx != 4'd15) idx <= idx + 4'd1;
            par <= ~par;
          end
        end
      end else if (half || acc) begin
        pix_valid <= 1'b1;
        pix_x     <= cx;
        pix_y     <= cy;
        pix_data  <= (half ? hold : in_data[15:0]) | {env6[0], 15'd0};
        if (!half) hold <= in_data[31:16];
        if (pix_last) begin
          st <= S_CMD; img_busy <= 1'b0; half <= 1'b0;
        end else begin
          half <= !half;
          if (col == wm1) begin
            col <= '0; row <= row + 9'd1; cx <= x0; cy <= cy + 9'd1;
          end else begin
            col <= col + 10'd1; cx <= cx + 10'd1;
          end
        end
      end
    end
  end

  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_valid, copy_valid, read_valid, pix_valid}));

  assert_payload_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && img_busy) |=> pix_valid);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(img_busy) |-> pix_valid);

  assert_no_pixel_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(img_busy));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(status));

  assert_half_rate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && img_busy) |=> (!in_ready || !img_busy));

endmodule

// File: tb/test_gpu_packet_framer.sv
module test_gpu_packet_framer;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, pkt_valid, pkt_first, pkt_last, copy_valid, read_valid, pix_valid, img_busy;
  logic [31:0] pkt_data;
  logic [3:0] pkt_len;
  logic [9:0] rect_x, copy_dst_x, pix_x, rect_h;
  logic [8:0] rect_y, copy_dst_y, pix_y;
  logic [10:0] rect_w;
  logic [15:0] pix_data;
  logic [12:0] status;

  always #4 clk = ~clk;

  gpu_packet_framer i_gpu_packet_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_first(pkt_first), .pkt_last(pkt_last),
    .pkt_len(pkt_len), .copy_valid(copy_valid), .read_valid(read_valid),
    .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h),
    .copy_dst_x(copy_dst_x), .copy_dst_y(copy_dst_y), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data), .status(status), .img_busy(img_busy));

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] pw [0:31];
  logic pf [0:31], pl [0:31];
  logic [3:0] pn [0:31];
  logic [9:0] qx [0:31];
  logic [8:0] qy [0:31];
  logic [15:0] qd [0:31];
  int np = 0, nx = 0, nc = 0, nr = 0;

  always @(negedge clk) if (rst_n) begin
    if (pkt_valid && np < 32) begin
      pw[np] = pkt_data; pf[np] = pkt_first; pl[np] = pkt_last; pn[np] = pkt_len; np++;
    end
    if (pix_valid && nx < 32) begin
      qx[nx] = pix_x; qy[nx] = pix_y; qd[nx] = pix_data; nx++;
    end
    if (copy_valid) nc++;
    if (read_valid) nr++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear();
    np = 0; nx = 0; nc = 0; nr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 in_ready", in_ready, 1);
    chk("R1 img_busy", img_busy, 0);
    chk("R1 status", status, 0);
    chk("R1 valids", {pkt_valid, copy_valid, read_valid, pix_valid}, 0);
  endtask

  task automatic t_generic();
    clear();
    send(32'h2011_1111); send(32'h1); send(32'h2); send(32'h3);
    idle(2);
    chk("R2 op20 count", np, 4);
    chk("R2 op20 word0", pw[0], 32'h2011_1111);
    chk("R2 op20 first", {pf[0], pf[1]}, 2'b10);
    chk("R2 op20 last", {pl[2], pl[3]}, 2'b01);
    chk("R2 op20 len", pn[0], 3);
    clear();
    send(32'h3C00_0000);
    for (int i = 1; i <= 11; i++) send(i);
    idle(2);
    chk("R2 op3C count", np, 12);
    chk("R2 op3C last", {pl[10], pl[11]}, 2'b01);
    chk("R2 op3C len", pn[11], 11);
    clear();
    send(32'h6000_0000); send(32'h5); send(32'h6);
    send(32'h0000_0000); send(32'h6C00_0000);
    idle(2);
    chk("R2 op60/00/6C count", np, 5);
    chk("R2 op60 last", pl[2], 1);
    chk("R2 op00 single", {pf[3], pl[3], pn[3]}, {2'b11, 4'd0});
    chk("R2 op6C single", {pf[4], pl[4], pn[4]}, {2'b11, 4'd0});
  endtask

  task automatic t_poly();
    clear();
    send(32'h4800_0000); send(32'h0001_0001); send(32'h5000_5000);
    send(32'h0002_0002); send(32'h5555_5555);
    send(32'h0000_0000);
    idle(2);
    chk("R3 mono count", np, 6);
    chk("R3 mono early term ignored", pl[2], 0);
    chk("R3 mono end", pl[4], 1);
    chk("R3 next packet first", pf[5], 1);
    clear();
    send(32'h5800_0000); send(32'h0); send(32'h5000_5000); send(32'h0);
    send(32'h1111_1111); send(32'h5AAA_5AAA); send(32'h5000_5000);
    idle(2);
    chk("R3 shaded count", np, 7);
    chk("R3 shaded odd term ignored", pl[5], 0);
    chk("R3 shaded end", pl[6], 1);
  endtask

  task automatic t_copy();
    clear();
    send(32'h9F00_0000); send(32'h0010_0020); send(32'h0005_03FF); send(32'h0002_0003);
    idle(2);
    chk("R4 copy pulse", nc, 1);
    chk("R4 no pkt", np, 0);
    chk("R4 src", {rect_x, rect_y}, {10'h20, 9'h10});
    chk("R4 dst", {copy_dst_x, copy_dst_y}, {10'h3FF, 9'h5});
    chk("R6 copy size", {rect_w, rect_h}, {11'd3, 10'd2});
  endtask

  task automatic t_read();
    clear();
    send(32'hC000_0000); send(32'h0123_0045); send(32'h0000_0000);
    idle(2);
    chk("R5 read pulse", nr, 1);
    chk("R5 read pos", {rect_x, rect_y}, {10'h45, 9'h123});
    chk("R6 size zero", {rect_w, rect_h}, {11'd1024, 10'd512});
    chk("R5 busy low", img_busy, 0);
    send(32'hDF00_0000); send(32'h0); send(32'h0201_0401);
    idle(2);
    chk("R6 size 0x401/0x201", {rect_w, rect_h}, {11'd1, 10'd1});
    chk("R5 no pixels or pkt", {nx[7:0], np[7:0], nr[7:0]}, {8'd0, 8'd0, 8'd2});
  endtask

  task automatic t_env();
    clear();
    send(32'hE100_0123);
    idle(1);
    chk("R10 env1", status, 13'h0123);
    send(32'hE600_0003);
    idle(1);
    chk("R10 env6", status, 13'h1923);
    send(32'hE2FF_FFFF); send(32'hE7FF_FFFF);
    idle(1);
    chk("R10 other env unchanged", status, 13'h1923);
    chk("R10 no echo", np, 0);
    send(32'hE600_0000); send(32'hE100_0000);
    idle(1);
    chk("R10 cleared", status, 0);
  endtask

  task automatic t_write();
    logic [9:0]  ex [0:5] = '{10'd1022, 10'd1023, 10'd0, 10'd1022, 10'd1023, 10'd0};
    logic [8:0]  ey [0:5] = '{9'd511, 9'd511, 9'd511, 9'd0, 9'd0, 9'd0};
    logic [15:0] ed [0:5] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666};
    clear();
    send(32'hA000_0000); send(32'h01FF_03FE); send(32'h0002_0003);
    idle(1);
    chk("R7 busy after header", img_busy, 1);
    send(32'h2222_1111);
    chk("R11 ready low after payload word", in_ready, 0);
    send(32'h4444_3333); send(32'h6666_5555);
    idle(3);
    chk("R7 pixel count", nx, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R8 pixel address", {qx[i], qy[i]}, {ex[i], ey[i]});
      chk("R7 pixel order", qd[i], ed[i]);
    end
    chk("R7 busy cleared", img_busy, 0);
    send(32'h0000_0007);
    idle(2);
    chk("R7 parsing resumed", {np[7:0], pw[0]}, {8'd1, 32'h7});
  endtask

  task automatic t_odd_mask();
    send(32'hE600_0001);
    idle(1);
    clear();
    send(32'hBF00_0000); send(32'h0007_0005); send(32'h0001_0001);
    send(32'hBEEF_1234); send(32'h0000_0009);
    idle(2);
    chk("R9 mask pixel", {nx[7:0], qd[0]}, {8'd1, 16'h9234});
    chk("R8 pixel pos", {qx[0], qy[0]}, {10'd5, 9'd7});
    chk("R11 upper half dropped", {np[7:0], pw[0]}, {8'd1, 32'h9});
    chk("R10 status mask bit", status, 13'h0800);
    send(32'hE600_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_generic();
    t_poly();
    t_copy();
    t_read();
    t_env();
    t_write();
    t_odd_mask();
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule